// File: doc/BRIEF.md
# In-order packet completion tracker

This block sits beside a receive-side DMA engine. It follows packets whose descriptors and payload are being written to memory. A packet's descriptor pointer goes back to a return queue only once every write issued for that packet has been acknowledged. Packets are entered on a fetch port in fetch order, each with a descriptor pointer and a packet ID. The ID tags every write the engine issues, every write status that comes back, and a marker that says the engine has issued the packet's final write.

Write responses may complete packets in any order. The tracker holds a finished packet until all older packets have left, so pointers retire strictly in fetch order on a valid/ready return port. A write status that reports an error marks its packet, and the mark travels with the pointer. Tracking is active only while the channel is in pass-by-reference mode. In any other mode the tracker ignores its inputs.

Top module: `pkt_order_tracker`

## Requirements
- R1: After reset `ret_valid_o` is 0, and `fetch_ready_o` is 1 while `mode_pbr_i` is 1.
- R2: Pointers leave the return port in exactly the order their packets were accepted on the fetch port. A younger packet that completes first waits until every older packet has retired.
- R3: A packet is not offered on the return port until its last-write marker has been seen and a write status has come back for every write issued with its ID.
- R4: Each accepted issue strobe adds one to the packet's outstanding count, and each response strobe removes one. An issue strobe and a response strobe for the same ID in the same cycle leave the count unchanged.
- R5: Up to DEPTH (default 8) packets are in flight. `fetch_ready_o` is 0 while all DEPTH entries are occupied, and a fetch offered then is not taken.
- R6: A response with `resp_err_i`=1 sets a sticky error flag on its packet. The packet still retires in order, with `ret_err_o`=1 alongside its pointer. A newly fetched packet starts with the flag clear.
- R7: While `mode_pbr_i` is 0, `fetch_ready_o` is 0, and fetch, issue, response and last-write inputs have no effect on any entry.
- R8: While `ret_valid_o` is 1 and `ret_ready_i` is 0, the return port keeps `ret_valid_o`, `ret_ptr_o` and `ret_err_o` unchanged in the next cycle.
- R9: When the oldest packet becomes complete through a response or last-write strobe sampled at a clock edge, `ret_valid_o` is 1 directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_pbr_i | input | 1 | Channel is in pass-by-reference mode; tracking enabled |
| fetch_valid_i | input | 1 | New packet offered |
| fetch_ready_o | output | 1 | Tracker can accept a packet |
| fetch_ptr_i | input | PTR_W | Descriptor pointer of new packet |
| fetch_id_i | input | ID_W | Packet ID of new packet |
| issue_valid_i | input | 1 | A write was issued |
| issue_id_i | input | ID_W | Packet ID of issued write |
| resp_valid_i | input | 1 | A write status returned |
| resp_id_i | input | ID_W | Packet ID of returned status |
| resp_err_i | input | 1 | Returned status reports an error |
| last_valid_i | input | 1 | Final write of a packet has been issued |
| last_id_i | input | ID_W | Packet ID of that final write |
| ret_valid_o | output | 1 | Oldest packet ready to return |
| ret_ready_i | input | 1 | Return queue accepts pointer |
| ret_ptr_o | output | PTR_W | Returned descriptor pointer |
| ret_err_o | output | 1 | Returned packet saw a write error |

## Verification
Every strobe is registered into its entry at one clock edge. The return port is decoded combinationally from the oldest entry, so a completing strobe shows on `ret_valid_o` right after the edge that samples it. `fetch_ready_o` changes right after the edge that fills or frees the last entry. The bench drives every input at a falling edge, so each strobe is sampled at the following rising edge, and it reads the outputs at the falling edge after that. The negative checks use the same timing. A packet that must not retire yet, or a strobe that must be ignored, is checked at the falling edge after the stimulus, before the next strobe that could legitimately complete the packet.

// File: rtl/pot_pkg.sv
package pot_pkg;
  typedef struct packed {
    logic busy;
    logic last;
    logic err;
  } ent_flags_t;
endpackage

// File: rtl/pot_ring.sv
module pot_ring #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o,
  output logic [OCC_W-1:0] occ_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [OCC_W-1:0] occ_q;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      if (push_i && !pop_i)      occ_q <= occ_q + 1'b1;
      else if (!push_i && pop_i) occ_q <= occ_q - 1'b1;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign occ_o  = occ_q;
  assign full_o = (occ_q == OCC_W'(DEPTH));
endmodule

// File: rtl/pot_entry.sv
module pot_entry
  import pot_pkg::*;
#(
  parameter int ID_W  = 3,
  parameter int PTR_W = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trk_en_i,
  input  logic             alloc_i,
  input  logic             free_i,
  input  logic [ID_W-1:0]  alloc_id_i,
  input  logic [PTR_W-1:0] alloc_ptr_i,
  input  logic             issue_valid_i,
  input  logic [ID_W-1:0]  issue_id_i,
  input  logic             resp_valid_i,
  input  logic [ID_W-1:0]  resp_id_i,
  input  logic             resp_err_i,
  input  logic             last_valid_i,
  input  logic [ID_W-1:0]  last_id_i,
  output logic             done_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             err_o
);
  ent_flags_t       fl_q;
  logic [ID_W-1:0]  id_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit_iss, hit_rsp, hit_last, live;

  assign live     = trk_en_i && fl_q.busy;
  assign hit_iss  = live && issue_valid_i && (issue_id_i == id_q);
  assign hit_rsp  = live && resp_valid_i  && (resp_id_i  == id_q);
  assign hit_last = live && last_valid_i  && (last_id_i  == id_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q  <= '0;
      id_q  <= '0;
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (alloc_i) begin
      fl_q  <= '{busy: 1'b1, last: 1'b0, err: 1'b0};
      id_q  <= alloc_id_i;
      ptr_q <= alloc_ptr_i;
      cnt_q <= '0;
    end else if (free_i) begin
      fl_q.busy <= 1'b0;
    end else begin
      // simultaneous issue and response cancel
      if (hit_iss && !hit_rsp && (cnt_q != '1))      cnt_q <= cnt_q + 1'b1;
      else if (hit_rsp && !hit_iss && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
      if (hit_rsp && resp_err_i) fl_q.err  <= 1'b1;
      if (hit_last)              fl_q.last <= 1'b1;
    end
  end

  assign done_o = fl_q.busy && fl_q.last && (cnt_q == '0);
  assign ptr_o  = ptr_q;
  assign err_o  = fl_q.err;
endmodule

// File: rtl/pkt_order_tracker.sv
module pkt_order_tracker #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int PTR_W = 32,
  parameter int CNT_W = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_pbr_i,
  input  logic             fetch_valid_i,
  output logic             fetch_ready_o,
  input  logic [PTR_W-1:0] fetch_ptr_i,
  input  logic [ID_W-1:0]  fetch_id_i,
  input  logic             issue_valid_i,
  input  logic [ID_W-1:0]  issue_id_i,
  input  logic             resp_valid_i,
  input  logic [ID_W-1:0]  resp_id_i,
  input  logic             resp_err_i,
  input  logic             last_valid_i,
  input  logic [ID_W-1:0]  last_id_i,
  output logic             ret_valid_o,
  input  logic             ret_ready_i,
  output logic [PTR_W-1:0] ret_ptr_o,
  output logic             ret_err_o
);
  logic [IDX_W-1:0] head, tail;
  logic [OCC_W-1:0] occ_q;
  logic             full, push, pop;
  logic [DEPTH-1:0] done_v, err_v;
  logic [PTR_W-1:0] ptr_v [DEPTH];

  assign fetch_ready_o = mode_pbr_i && !full;
  assign push          = fetch_valid_i && fetch_ready_o;
  assign pop           = ret_valid_o && ret_ready_i;

  pot_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .head_o (head),
    .tail_o (tail),
    .full_o (full),
    .occ_o  (occ_q)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    pot_entry #(.ID_W(ID_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ent (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .trk_en_i      (mode_pbr_i),
      .alloc_i       (push && (tail == IDX_W'(g))),
      .free_i        (pop && (head == IDX_W'(g))),
      .alloc_id_i    (fetch_id_i),
      .alloc_ptr_i   (fetch_ptr_i),
      .issue_valid_i (issue_valid_i),
      .issue_id_i    (issue_id_i),
      .resp_valid_i  (resp_valid_i),
      .resp_id_i     (resp_id_i),
      .resp_err_i    (resp_err_i),
      .last_valid_i  (last_valid_i),
      .last_id_i     (last_id_i),
      .done_o        (done_v[g]),
      .ptr_o         (ptr_v[g]),
      .err_o         (err_v[g])
    );
  end

  assign ret_valid_o = done_v[head];
  assign ret_ptr_o   = ptr_v[head];
  assign ret_err_o   = err_v[head];
endmodule

// File: rtl/pot_checker.sv
module pot_checker #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 32,
  parameter int OCC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             fetch_ready_i,
  input logic             ret_valid_i,
  input logic             ret_ready_i,
  input logic [PTR_W-1:0] ret_ptr_i,
  input logic             ret_err_i,
  input logic [OCC_W-1:0] occ_i
);
  assert_full_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_i == OCC_W'(DEPTH)) |-> !fetch_ready_i);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= OCC_W'(DEPTH));

  assert_mode_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> !fetch_ready_i);

  assert_ret_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !ret_ready_i) |=> (ret_valid_i && $stable(ret_ptr_i) && $stable(ret_err_i)));

  assert_ret_needs_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i |-> (occ_i != '0));
endmodule

bind pkt_order_tracker pot_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OCC_W(OCC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_pbr_i),
  .fetch_ready_i (fetch_ready_o),
  .ret_valid_i   (ret_valid_o),
  .ret_ready_i   (ret_ready_i),
  .ret_ptr_i     (ret_ptr_o),
  .ret_err_i     (ret_err_o),
  .occ_i         (occ_q)
);

// File: tb/tb_pkt_order_tracker.sv
module tb_pkt_order_tracker;
  localparam int DEPTH = 8;
  localparam int ID_W  = 3;
  localparam int PTR_W = 32;

  logic clk = 0, rst_ni = 0, mode_pbr = 1;
  logic fetch_valid = 0, issue_valid = 0, resp_valid = 0, resp_err = 0, last_valid = 0;
  logic ret_ready = 0;
  logic [PTR_W-1:0] fetch_ptr = '0;
  logic [ID_W-1:0] fetch_id = '0, issue_id = '0, resp_id = '0, last_id = '0;
  logic fetch_ready, ret_valid, ret_err;
  logic [PTR_W-1:0] ret_ptr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pkt_order_tracker #(.DEPTH(DEPTH), .ID_W(ID_W), .PTR_W(PTR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_pbr_i(mode_pbr),
    .fetch_valid_i(fetch_valid), .fetch_ready_o(fetch_ready),
    .fetch_ptr_i(fetch_ptr), .fetch_id_i(fetch_id),
    .issue_valid_i(issue_valid), .issue_id_i(issue_id),
    .resp_valid_i(resp_valid), .resp_id_i(resp_id), .resp_err_i(resp_err),
    .last_valid_i(last_valid), .last_id_i(last_id),
    .ret_valid_o(ret_valid), .ret_ready_i(ret_ready),
    .ret_ptr_o(ret_ptr), .ret_err_o(ret_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [PTR_W-1:0] p, input logic [ID_W-1:0] id);
    @(negedge clk); fetch_valid = 1; fetch_ptr = p; fetch_id = id;
    @(negedge clk); fetch_valid = 0;
  endtask

  task automatic do_issue(input logic [ID_W-1:0] id);
    @(negedge clk); issue_valid = 1; issue_id = id;
    @(negedge clk); issue_valid = 0;
  endtask

  task automatic do_resp(input logic [ID_W-1:0] id, input logic e);
    @(negedge clk); resp_valid = 1; resp_id = id; resp_err = e;
    @(negedge clk); resp_valid = 0; resp_err = 0;
  endtask

  task automatic do_both(input logic [ID_W-1:0] id);
    @(negedge clk); issue_valid = 1; issue_id = id; resp_valid = 1; resp_id = id;
    @(negedge clk); issue_valid = 0; resp_valid = 0;
  endtask

  task automatic do_last(input logic [ID_W-1:0] id);
    @(negedge clk); last_valid = 1; last_id = id;
    @(negedge clk); last_valid = 0;
  endtask

  // called at a falling edge
  task automatic pop_expect(input string tag, input logic [PTR_W-1:0] p, input logic e);
    chk({tag, " valid"}, ret_valid, 1);
    chk({tag, " ptr"}, ret_ptr, p);
    chk({tag, " err"}, ret_err, e);
    ret_ready = 1;
    @(negedge clk); ret_ready = 0;
  endtask

  task automatic t_reset;
    chk("R1 ret_valid after reset", ret_valid, 0);
    chk("R1 fetch_ready after reset", fetch_ready, 1);
  endtask

  task automatic t_basic;
    do_fetch(32'hA000, 3'd1);
    do_issue(3'd1); do_issue(3'd1); do_last(3'd1);
    chk("R3 held with two writes open", ret_valid, 0);
    do_resp(3'd1, 0);
    chk("R3 held with one write open", ret_valid, 0);
    do_resp(3'd1, 0);
    chk("R9 valid right after final response", ret_valid, 1);
    pop_expect("R3 basic", 32'hA000, 0);
    chk("R2 empty after pop", ret_valid, 0);
  endtask

  task automatic t_order;
    do_fetch(32'hB000, 3'd2); do_fetch(32'hC000, 3'd3);
    do_issue(3'd2); do_issue(3'd3); do_last(3'd2); do_last(3'd3);
    do_resp(3'd3, 0);
    chk("R2 younger done waits", ret_valid, 0);
    do_resp(3'd2, 0);
    repeat (3) @(negedge clk);
    chk("R8 hold ptr", ret_ptr, 32'hB000);
    pop_expect("R2 first", 32'hB000, 0);
    pop_expect("R2 second", 32'hC000, 0);
  endtask

  task automatic t_same_cycle;
    do_fetch(32'hD000, 3'd4);
    do_issue(3'd4); do_both(3'd4); do_last(3'd4);
    chk("R4 same-cycle issue+resp keeps count", ret_valid, 0);
    do_resp(3'd4, 0);
    pop_expect("R4 count returns to zero", 32'hD000, 0);
  endtask

  task automatic t_error;
    do_fetch(32'hE000, 3'd5);
    do_issue(3'd5); do_issue(3'd5); do_last(3'd5);
    do_resp(3'd5, 1); do_resp(3'd5, 0);
    pop_expect("R6 sticky error", 32'hE000, 1);
    do_fetch(32'hF000, 3'd5);
    do_last(3'd5);
    pop_expect("R6 flag cleared on new packet", 32'hF000, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) do_fetch(32'h100 + i, ID_W'(DEPTH - 1 - i));
    chk("R5 fetch_ready low when full", fetch_ready, 0);
    do_fetch(32'hDEAD, 3'd0);
    for (int i = 0; i < DEPTH; i++) do_last(ID_W'(i));
    pop_expect("R5 first after full", 32'h100, 0);
    chk("R5 fetch_ready after one pop", fetch_ready, 1);
    for (int i = 1; i < DEPTH; i++) pop_expect("R2 full drain", 32'h100 + i, 0);
    chk("R5 refused fetch not stored", ret_valid, 0);
  endtask

  task automatic t_mode;
    do_fetch(32'h6000, 3'd1);
    do_issue(3'd1); do_last(3'd1);
    @(negedge clk); mode_pbr = 0;
    @(negedge clk);
    chk("R7 fetch_ready low in other mode", fetch_ready, 0);
    do_resp(3'd1, 0);
    do_fetch(32'h7000, 3'd2);
    @(negedge clk); mode_pbr = 1;
    @(negedge clk);
    chk("R7 response ignored", ret_valid, 0);
    do_resp(3'd1, 0);
    pop_expect("R7 resumes", 32'h6000, 0);
    do_last(3'd2);
    chk("R7 fetch ignored", ret_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_same_cycle();
    t_error();
    t_full();
    t_mode();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule